// File: doc/BRIEF.md
# Deskewable NRZI Write Channel

This block drives one track of a tape write head. Data arrives one bit at a time with a strobe. A strobed one schedules a single reversal of the output level. A strobed zero leaves the level alone. The result is NRZI recording. The reversal does not happen at once. A small down-counter runs on a fast clock, at 32 times the data rate, and times a delay before each reversal. The per-channel delay lets every data track be lined up in time with a reference track.

A data channel takes its delay from a 4-bit skew pattern. Each bit of the pattern stands for an open switch, and opening more switches shortens the delay. A channel built in reference mode ignores the pattern and always waits a fixed number of counts. A separate clear input forces the output level low and drops any reversal that is still pending. The channel provides a complementary pair of outputs, one for each leg of the head driver.

Top module: `nrzi_skew_writer`

## Requirements
- R1: After reset is asserted, `head_p` is 0 and `head_n` is 1, and no reversal is pending.
- R2: A strobe sampled with `data_bit` at 1 causes exactly one reversal of `head_p`. A strobe sampled with `data_bit` at 0 causes no reversal.
- R3: In a data channel, the reversal lands 16 − `skew_open` clock edges after the edge that samples the strobe. The skew value is read as an unsigned 4-bit number, so a value of 0 gives 16 edges and a value of 15 gives 1 edge, which is the minimum.
- R4: In reference mode (`REF_MODE`=1), the reversal lands 8 edges after the sampling edge, whatever the value of `skew_open`.
- R5: A strobed one that arrives while a reversal is still pending cancels the pending reversal and restarts the delay from the newly loaded value. This holds even if the pending reversal was due on that same edge.
- R6: A strobed zero that arrives while a reversal is pending has no effect on that reversal or on its timing.
- R7: When `amp_clr` is high at an edge, `head_p` is 0 after that edge and any pending reversal is dropped. `amp_clr` takes priority over a strobe on the same edge.
- R8: `head_n` is always the complement of `head_p`.
- R9: Once a reversal has happened, the counter is idle, and no further reversal happens until a new strobed one arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 32 times the data rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | One-cycle data strobe |
| data_bit | input | 1 | Bit to write, qualified by `strobe` |
| skew_open | input | SKEW_W | Open-switch pattern; a higher value gives a shorter delay |
| amp_clr | input | 1 | Synchronous clear of the output level and of any pending reversal |
| head_p | output | 1 | NRZI level for the first head-driver leg |
| head_n | output | 1 | Complement of `head_p` for the second leg |

## Verification
A wrong preload value or a wrong terminal count shows up as a reversal landing on the wrong edge. At the latest this is visible 16 edges after the strobe, since that is the longest delay. A counter that does not lock shows up as repeated reversals with no strobe. A restart that fails to cancel the old count shows up as an extra reversal within the old delay window. A clear that leaves stale state shows up as a late reversal after `amp_clr`. The scoreboard treats every change of `head_p` as an event. It matches each change against an expected edge number, so both an early or late change and an unexpected change are caught on the edge where they occur.

// File: rtl/nrzi_skew_writer.sv
module nrzi_skew_writer #(
  parameter int SKEW_W    = 4,
  parameter bit REF_MODE  = 1'b0,
  parameter int REF_DELAY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              data_bit,
  input  logic [SKEW_W-1:0] skew_open,
  input  logic              amp_clr,
  output logic              head_p,
  output logic              head_n
);
  localparam int CNT_W = SKEW_W + 1;
  localparam logic [CNT_W-1:0] SPAN = CNT_W'(1 << SKEW_W);

  logic             level;
  logic             busy;
  logic [CNT_W-1:0] cnt;

  wire             launch  = strobe & data_bit;
  wire [CNT_W-1:0] preload = REF_MODE ? CNT_W'(REF_DELAY) : SPAN - {1'b0, skew_open};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (amp_clr) begin
      level <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= preload;
    end else if (busy) begin
      if (cnt == CNT_W'(1)) begin
        level <= ~level;
        busy  <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign head_p = level;
  assign head_n = ~level;
endmodule

module nrzi_skew_writer_chk #(
  parameter int SKEW_W    = 4,
  parameter bit REF_MODE  = 1'b0,
  parameter int REF_DELAY = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic              data_bit,
  input logic              amp_clr,
  input logic              head_p,
  input logic              head_n,
  input logic              busy,
  input logic [SKEW_W:0]   cnt
);
  localparam int SPAN = 1 << SKEW_W;

  assert_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    head_n == !head_p);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    amp_clr |=> (!head_p && !busy));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !amp_clr) |=> $stable(head_p));

  assert_launch_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && data_bit && !amp_clr) |=> busy);

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0 && int'(cnt) <= SPAN));

  generate
    if (REF_MODE) begin : g_ref
      assert_ref_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && data_bit && !amp_clr) |=> (int'(cnt) == REF_DELAY));
    end
  endgenerate
endmodule

bind nrzi_skew_writer nrzi_skew_writer_chk #(
  .SKEW_W(SKEW_W), .REF_MODE(REF_MODE), .REF_DELAY(REF_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .data_bit(data_bit),
  .amp_clr(amp_clr), .head_p(head_p), .head_n(head_n),
  .busy(busy), .cnt(cnt)
);

// File: tb/test_nrzi_skew_writer.sv
module test_nrzi_skew_writer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic       data_bit = 1'b0;
  logic [3:0] skew_open = 4'd0;
  logic       amp_clr = 1'b0;
  logic       hp, hn, rp, rn;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int q_dat[$];
  int q_ref[$];
  logic last_d = 1'b0;
  logic last_r = 1'b0;
  bit   mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nrzi_skew_writer #(.REF_MODE(1'b0)) i_nrzi_skew_writer (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .data_bit(data_bit),
    .skew_open(skew_open), .amp_clr(amp_clr), .head_p(hp), .head_n(hn));

  nrzi_skew_writer #(.REF_MODE(1'b1)) i_nrzi_skew_writer_ref (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .data_bit(data_bit),
    .skew_open(skew_open), .amp_clr(amp_clr), .head_p(rp), .head_n(rn));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected edge numbers as head_p changes.
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      check(hn == !hp, "R8 data complement", int'(hn), int'(!hp));
      check(rn == !rp, "R8 ref complement", int'(rn), int'(!rp));
      if (amp_clr) begin
        check(hp == 1'b0, "R7 data clear", int'(hp), 0);
        check(rp == 1'b0, "R7 ref clear", int'(rp), 0);
      end else begin
        if (hp != last_d) begin
          if (q_dat.size() == 0) check(1'b0, "R9 data unexpected toggle", cyc, -1);
          else begin
            int e; e = q_dat.pop_front();
            check(cyc == e, "R3 data toggle edge", cyc, e);
          end
        end
        if (rp != last_r) begin
          if (q_ref.size() == 0) check(1'b0, "R9 ref unexpected toggle", cyc, -1);
          else begin
            int e; e = q_ref.pop_front();
            check(cyc == e, "R4 ref toggle edge", cyc, e);
          end
        end
      end
      last_d = hp;
      last_r = rp;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit b, input logic [3:0] sk);
    @(negedge clk);
    strobe = 1'b1; data_bit = b; skew_open = sk;
    if (b) begin
      if (q_dat.size() > 0 && q_dat[$] > cyc) void'(q_dat.pop_back());  // R5
      if (q_ref.size() > 0 && q_ref[$] > cyc) void'(q_ref.pop_back());
      q_dat.push_back(cyc + 1 + (16 - int'(sk)));
      q_ref.push_back(cyc + 1 + 8);
    end
    @(negedge clk);
    strobe = 1'b0; data_bit = 1'b0;
  endtask

  task automatic clear_with_strobe(input bit with_strobe);
    @(negedge clk);
    amp_clr = 1'b1;
    if (with_strobe) begin strobe = 1'b1; data_bit = 1'b1; end
    q_dat.delete();
    q_ref.delete();
    @(negedge clk);
    amp_clr = 1'b0; strobe = 1'b0; data_bit = 1'b0;
  endtask

  initial begin
    fork
      begin
        idle(3);
        check(hp == 1'b0 && hn == 1'b1, "R1 reset data", int'(hp), 0);
        check(rp == 1'b0 && rn == 1'b1, "R1 reset ref", int'(rp), 0);
        rst_n = 1'b1;
        idle(1);
        mon_on = 1'b1;
        send(1'b1, 4'd0);  idle(20);   // R3 max delay 16
        send(1'b1, 4'd15); idle(20);   // R3 min delay 1
        send(1'b1, 4'd4);  idle(20);   // R2 one bit
        send(1'b0, 4'd9);  idle(20);   // R2 zero bit: no toggle
        check(q_dat.size() == 0, "R2 zero bit queue", q_dat.size(), 0);
        send(1'b1, 4'd0);  idle(4);
        send(1'b1, 4'd8);  idle(20);   // R5 restart
        send(1'b1, 4'd10); idle(1);
        send(1'b1, 4'd3);  idle(20);   // R5 restart at due edge region
        send(1'b1, 4'd0);  idle(3);
        send(1'b0, 4'd15); idle(20);   // R6 zero while pending
        send(1'b1, 4'd0);  idle(3);
        clear_with_strobe(1'b0); idle(20);  // R7 clear cancels pending
        send(1'b1, 4'd12); idle(20);
        clear_with_strobe(1'b1); idle(20);  // R7 clear beats strobe
        check(hp == 1'b0, "R7 data stays low", int'(hp), 0);
        check(rp == 1'b0, "R7 ref stays low", int'(rp), 0);
        for (int k = 0; k < 4; k++) begin
          send(1'b1, 4'(k * 5)); idle(20);
        end
        idle(5);
        check(q_dat.size() == 0, "R9 data drained", q_dat.size(), 0);
        check(q_ref.size() == 0, "R9 ref drained", q_ref.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule